// File: doc/BRIEF.md
# Cacheable Line-Fill Read Bus Controller

This block is the processor-side sequencer for read cycles that may fill a cache line. The core presents a request with an address, a cacheability attribute and a page write-policy attribute. The controller opens a bus cycle with a one-clock address strobe. In that same clock it drives a cacheable indication and a page-writethrough indication, and it holds both until the cycle ends. The data phase then starts. Every beat stays pending until the system returns ready. With no wait states, the beats arrive in consecutive clocks.

At the first ready the controller also samples the system's cache-enable and writeback inputs, and it makes its one decision there. If both sides agree that the access is cacheable, the cycle continues as a four-beat burst. Otherwise it ends at once as a single-transfer read. For a burst, the line is reported as exclusive when both sides agree on writeback, and as shared when either side asks for writethrough. Each beat's data lands in a four-entry line buffer at the interleaved beat index. That index is the XOR of the first quadword's position within the line and the beat number. A read port gives access to the buffer.

Top module: `lfill_bus_ctl`

## Requirements
- R1: A request is accepted only while `req_ready` is 1, which is only when no cycle is open. `addr_strobe` is 1 for exactly the one clock that follows the accepting edge. `bus_addr` carries `req_addr[ADDR_W-1:3]` from that clock until the cycle ends.
- R2: `cache_req` equals the request's cacheable attribute and `pwt_out` equals its page-writethrough attribute, both from the strobe clock to the end of the cycle. A non-cacheable request never raises `cache_req`. Both are 0 while idle.
- R3: The clock edge that ends the strobe clock ignores `rdy_in`. After that, a beat completes only at an edge where `rdy_in` is 1, and any number of wait clocks is allowed. With `rdy_in` held at 1, the beats complete on consecutive edges.
- R4: `ken_in` and `wbwt_in` are sampled only at the first beat's ready. Their values on later beats have no effect.
- R5: When `cache_req` is 1 and `ken_in` is 1 at the first ready, the cycle runs exactly four beats.
- R6: When `cache_req` or `ken_in` is 0 at the first ready, the cycle ends after that one beat, and `line_valid` stays 0.
- R7: `line_state` uses the encoding invalid=0, shared=1, exclusive=2. It is exclusive when `pwt_out` is 0 and the sampled `wbwt_in` is 1. It is shared when either of those indicates writethrough. It is invalid in every clock in which `line_valid` is 0.
- R8: Beat b of a cycle (b = 0..3) is written to buffer entry `req_addr[4:3] XOR b`. Reading entry i through `rd_idx` returns its contents combinationally.
- R9: `cyc_done` is a one-clock pulse in the clock after the edge of the final ready. `line_valid` pulses in the same clock for bursts only. `req_ready` is 1 again in that clock.
- R10: While `rst` is high at a clock edge, the controller returns to idle: `req_ready` is 1 and all other control outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core read request |
| req_addr | input | ADDR_W | Request byte address |
| req_cacheable | input | 1 | Core marks the access cacheable |
| req_pwt | input | 1 | Core page attribute: writethrough |
| req_ready | output | 1 | Controller idle, request accepted |
| addr_strobe | output | 1 | One-clock address strobe |
| bus_addr | output | ADDR_W-3 | Quadword address on the bus |
| cache_req | output | 1 | Cacheable indication to the system |
| pwt_out | output | 1 | Page-writethrough indication to the system |
| rdy_in | input | 1 | Beat ready from the system |
| ken_in | input | 1 | System cache-enable |
| wbwt_in | input | 1 | System write policy, 1 = writeback |
| data_in | input | DATA_W | Read data bus |
| cyc_done | output | 1 | Cycle finished pulse |
| line_valid | output | 1 | Full line filled pulse |
| line_state | output | 2 | Coherency state of the filled line |
| rd_idx | input | 2 | Line buffer read index |
| rd_data | output | DATA_W | Line buffer read data |

## Verification
The strobe is due one clock after the accepting edge. The first beat can complete no earlier than the edge that ends the following clock. `cyc_done`, `line_valid` and `line_state` are due in the clock after the final ready's edge. Buffer contents are readable from that same clock. The bench drives inputs and samples outputs at falling edges and keeps a fixed schedule: it checks the strobe in the clock after the request, holds `rdy_in` low for a chosen number of wait clocks, and checks the completion outputs exactly one falling edge after each ready is presented. It sweeps every combination of cacheability, page policy, cache-enable, writeback, first-quadword position and wait count from zero to two. On later beats it drives inverted cache-enable and writeback values, so that any late sampling shows up.

// File: rtl/lfill_pkg.sv
package lfill_pkg;

    localparam int LINE_BEATS = 4;
    localparam int BEAT_IDX_W = $clog2(LINE_BEATS);

    typedef enum logic [1:0] {
        ST_INV = 2'd0,
        ST_SHR = 2'd1,
        ST_EXC = 2'd2,
        ST_MOD = 2'd3
    } line_state_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_STROBE = 2'd1,
        PH_DATA   = 2'd2
    } phase_e;

    typedef struct packed {
        logic                  cacheable;
        logic                  pwt;
        logic [BEAT_IDX_W-1:0] first_qw;
    } req_attr_t;

    typedef struct packed {
        logic        burst;
        line_state_e state;
    } fill_dec_t;

    // interleaved position of a beat inside the line
    function automatic logic [BEAT_IDX_W-1:0] beat_slot(
        input logic [BEAT_IDX_W-1:0] first_qw,
        input logic [BEAT_IDX_W-1:0] beat
    );
        return first_qw ^ beat;
    endfunction

    // both sides must agree on cacheability and write policy
    function automatic fill_dec_t decide_fill(
        input logic cache_out,
        input logic ken,
        input logic pwt,
        input logic wbwt
    );
        fill_dec_t d;
        d.burst = cache_out & ken;
        if (!d.burst)
            d.state = ST_INV;
        else if (!pwt && wbwt)
            d.state = ST_EXC;
        else
            d.state = ST_SHR;
        return d;
    endfunction

endpackage

// File: rtl/lfill_seq.sv
module lfill_seq
    import lfill_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic [ADDR_W-1:3]     req_qaddr,
    input  req_attr_t             req_attr,
    input  logic                  rdy_in,
    input  fill_dec_t             dec_live,
    output phase_e                phase,
    output req_attr_t             attr_q,
    output logic [ADDR_W-1:3]     addr_q,
    output logic                  first_rdy,
    output logic                  last_rdy,
    output logic                  wr_en,
    output logic [BEAT_IDX_W-1:0] wr_idx
);

    localparam logic [BEAT_IDX_W-1:0] LAST_BEAT = BEAT_IDX_W'(LINE_BEATS - 1);

    logic [BEAT_IDX_W-1:0] beat;
    logic                  beat_ack;

    assign beat_ack  = (phase == PH_DATA) && rdy_in;
    assign first_rdy = beat_ack && (beat == '0);
    assign last_rdy  = beat_ack &&
                       ((beat == LAST_BEAT) || ((beat == '0) && !dec_live.burst));
    assign wr_en     = beat_ack;
    assign wr_idx    = beat_slot(attr_q.first_qw, beat);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            beat   <= '0;
            attr_q <= '0;
            addr_q <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (req_valid) begin
                        phase  <= PH_STROBE;
                        attr_q <= req_attr;
                        addr_q <= req_qaddr;
                        beat   <= '0;
                    end
                end
                PH_STROBE: begin
                    phase <= PH_DATA;
                    beat  <= '0;
                end
                PH_DATA: begin
                    if (last_rdy) begin
                        phase  <= PH_IDLE;
                        attr_q <= '0;
                        addr_q <= '0;
                        beat   <= '0;
                    end else if (beat_ack) begin
                        beat <= beat + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/lfill_policy.sv
module lfill_policy
    import lfill_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        first_rdy,
    input  logic        last_rdy,
    input  logic        cache_out,
    input  logic        pwt,
    input  logic        ken_in,
    input  logic        wbwt_in,
    output fill_dec_t   dec_live,
    output logic        cyc_done,
    output logic        line_valid,
    output line_state_e line_state
);

    fill_dec_t dec_now;
    fill_dec_t dec_q;

    assign dec_now  = decide_fill(cache_out, ken_in, pwt, wbwt_in);
    assign dec_live = first_rdy ? dec_now : dec_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_q      <= '{burst: 1'b0, state: ST_INV};
            cyc_done   <= 1'b0;
            line_valid <= 1'b0;
            line_state <= ST_INV;
        end else begin
            if (first_rdy)
                dec_q <= dec_now;
            cyc_done   <= last_rdy;
            line_valid <= last_rdy && dec_live.burst;
            line_state <= (last_rdy && dec_live.burst) ? dec_live.state : ST_INV;
        end
    end

endmodule

// File: rtl/lfill_linebuf.sv
module lfill_linebuf
    import lfill_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [BEAT_IDX_W-1:0] wr_idx,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [BEAT_IDX_W-1:0] rd_idx,
    output logic [DATA_W-1:0]     rd_data
);

    logic [DATA_W-1:0] slot [LINE_BEATS];

    for (genvar i = 0; i < LINE_BEATS; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slot[i] <= '0;
            else if (wr_en && (wr_idx == BEAT_IDX_W'(i)))
                slot[i] <= wr_data;
        end
    end

    assign rd_data = slot[rd_idx];

endmodule

// File: rtl/lfill_bus_ctl.sv
module lfill_bus_ctl
    import lfill_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_cacheable,
    input  logic              req_pwt,
    output logic              req_ready,
    output logic              addr_strobe,
    output logic [ADDR_W-4:0] bus_addr,
    output logic              cache_req,
    output logic              pwt_out,
    input  logic              rdy_in,
    input  logic              ken_in,
    input  logic              wbwt_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              cyc_done,
    output logic              line_valid,
    output logic [1:0]        line_state,
    input  logic [1:0]        rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    phase_e                phase;
    req_attr_t             req_attr;
    req_attr_t             attr_q;
    logic [ADDR_W-1:3]     addr_q;
    logic                  first_rdy;
    logic                  last_rdy;
    logic                  wr_en;
    logic [BEAT_IDX_W-1:0] wr_idx;
    fill_dec_t             dec_live;
    line_state_e           state_q;

    assign req_attr = '{cacheable: req_cacheable,
                        pwt:       req_pwt,
                        first_qw:  req_addr[3 +: BEAT_IDX_W]};

    lfill_seq #(.ADDR_W(ADDR_W)) i_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_qaddr (req_addr[ADDR_W-1:3]),
        .req_attr  (req_attr),
        .rdy_in    (rdy_in),
        .dec_live  (dec_live),
        .phase     (phase),
        .attr_q    (attr_q),
        .addr_q    (addr_q),
        .first_rdy (first_rdy),
        .last_rdy  (last_rdy),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx)
    );

    lfill_policy i_policy (
        .clk        (clk),
        .rst        (rst),
        .first_rdy  (first_rdy),
        .last_rdy   (last_rdy),
        .cache_out  (attr_q.cacheable),
        .pwt        (attr_q.pwt),
        .ken_in     (ken_in),
        .wbwt_in    (wbwt_in),
        .dec_live   (dec_live),
        .cyc_done   (cyc_done),
        .line_valid (line_valid),
        .line_state (state_q)
    );

    lfill_linebuf #(.DATA_W(DATA_W)) i_buf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (data_in),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    assign req_ready   = (phase == PH_IDLE);
    assign addr_strobe = (phase == PH_STROBE);
    assign bus_addr    = addr_q;
    assign cache_req   = (phase != PH_IDLE) && attr_q.cacheable;
    assign pwt_out     = (phase != PH_IDLE) && attr_q.pwt;
    assign line_state  = state_q;

endmodule

// File: rtl/lfill_bus_ctl_chk.sv
module lfill_bus_ctl_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_ready,
    input logic       addr_strobe,
    input logic       cache_req,
    input logic       pwt_out,
    input logic       rdy_in,
    input logic       cyc_done,
    input logic       line_valid,
    input logic [1:0] line_state
);

    logic [2:0] rdy_cnt;
    logic       pwt_lat;
    logic       cache_lat;
    logic       in_data;

    assign in_data = !req_ready && !addr_strobe;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdy_cnt   <= '0;
            pwt_lat   <= 1'b0;
            cache_lat <= 1'b0;
        end else if (addr_strobe) begin
            rdy_cnt   <= '0;
            pwt_lat   <= pwt_out;
            cache_lat <= cache_req;
        end else if (in_data && rdy_in) begin
            rdy_cnt <= rdy_cnt + 3'd1;
        end
    end

    // R1
    strobe_one_clk_chk: assert property (@(posedge clk) disable iff (rst)
        addr_strobe |=> !addr_strobe);

    // R1
    strobe_from_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(addr_strobe) |-> $past(req_ready));

    // R2
    cache_only_open_chk: assert property (@(posedge clk) disable iff (rst)
        (cache_req || pwt_out) |-> !req_ready);

    // R5
    burst_four_chk: assert property (@(posedge clk) disable iff (rst)
        line_valid |-> (rdy_cnt == 3'd4));

    // R6
    single_no_line_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_done && rdy_cnt == 3'd1) |-> !line_valid);

    // R6
    noncache_single_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_done && !cache_lat) |-> (!line_valid && rdy_cnt == 3'd1));

    // R7
    wt_shared_chk: assert property (@(posedge clk) disable iff (rst)
        (line_valid && pwt_lat) |-> (line_state == 2'd1));

    // R7
    idle_state_inv_chk: assert property (@(posedge clk) disable iff (rst)
        !line_valid |-> (line_state == 2'd0));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cyc_done |-> (req_ready && (rdy_cnt == 3'd1 || rdy_cnt == 3'd4)));

    // R9
    done_one_clk_chk: assert property (@(posedge clk) disable iff (rst)
        cyc_done |=> !cyc_done);

    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (req_ready && !addr_strobe && !cache_req && !pwt_out &&
                 !cyc_done && !line_valid));

endmodule

bind lfill_bus_ctl lfill_bus_ctl_chk i_lfill_chk (
    .clk         (clk),
    .rst         (rst),
    .req_ready   (req_ready),
    .addr_strobe (addr_strobe),
    .cache_req   (cache_req),
    .pwt_out     (pwt_out),
    .rdy_in      (rdy_in),
    .cyc_done    (cyc_done),
    .line_valid  (line_valid),
    .line_state  (line_state)
);

// File: tb/test_lfill_bus_ctl.sv
module test_lfill_bus_ctl;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 64;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_cacheable = 1'b0;
    logic              req_pwt = 1'b0;
    logic              req_ready;
    logic              addr_strobe;
    logic [ADDR_W-4:0] bus_addr;
    logic              cache_req;
    logic              pwt_out;
    logic              rdy_in = 1'b0;
    logic              ken_in = 1'b0;
    logic              wbwt_in = 1'b0;
    logic [DATA_W-1:0] data_in = '0;
    logic              cyc_done;
    logic              line_valid;
    logic [1:0]        line_state;
    logic [1:0]        rd_idx = '0;
    logic [DATA_W-1:0] rd_data;

    int checks = 0;
    int errors = 0;
    int run_no = 0;

    always #4 clk = ~clk;

    lfill_bus_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_lfill_bus_ctl (.*);

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s run=%0d actual=%0h expected=%0h", req, run_no, act, exp);
        end
    endtask

    function automatic logic [63:0] beat_data(input int run, input int b);
        return {16'hC3A5, 16'(run), 24'h5A0F00, 8'(b)};
    endfunction

    task automatic one_cycle(input bit c, input bit p, input bit k, input bit w,
                             input int f, input int ws);
        int beats;
        logic [1:0] exp_state;
        logic [ADDR_W-1:0] a;
        beats = (c && k) ? 4 : 1;
        exp_state = (c && k) ? ((!p && w) ? 2'd2 : 2'd1) : 2'd0;
        a = {16'h4000 + 16'(run_no), 11'h0, 2'(f), 3'b101};
        chk(req_ready == 1'b1, "R1 ready before request", 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_addr = a; req_cacheable = c; req_pwt = p;
        @(negedge clk);
        req_valid = 1'b0; req_cacheable = ~c; req_pwt = ~p;
        chk(addr_strobe == 1'b1, "R1 strobe", 64'(addr_strobe), 64'd1);
        chk(bus_addr == a[ADDR_W-1:3], "R1 bus address", 64'(bus_addr), 64'(a[ADDR_W-1:3]));
        chk(cache_req == c, "R2 cacheable with strobe", 64'(cache_req), 64'(c));
        chk(pwt_out == p, "R2 pwt with strobe", 64'(pwt_out), 64'(p));
        // ready during the strobe clock is ignored (R3)
        rdy_in = 1'b1; ken_in = ~k; wbwt_in = ~w; data_in = '1;
        @(negedge clk);
        rdy_in = 1'b0;
        chk(addr_strobe == 1'b0, "R1 strobe one clock", 64'(addr_strobe), 64'd0);
        chk(cyc_done == 1'b0, "R3 strobe-clock ready ignored", 64'(cyc_done), 64'd0);
        for (int b = 0; b < beats; b++) begin
            for (int i = 0; i < ws; i++) begin
                rdy_in = 1'b0; ken_in = ~k; wbwt_in = ~w;
                @(negedge clk);
                chk(cyc_done == 1'b0 && req_ready == 1'b0, "R3 wait holds beat",
                    64'(cyc_done), 64'd0);
            end
            rdy_in = 1'b1;
            ken_in = (b == 0) ? k : ~k;
            wbwt_in = (b == 0) ? w : ~w;
            data_in = beat_data(run_no, b);
            @(negedge clk);
            rdy_in = 1'b0; ken_in = ~k; wbwt_in = ~w;
            if (b < beats - 1) begin
                chk(cyc_done == 1'b0, "R5 burst continues", 64'(cyc_done), 64'd0);
                chk(cache_req == c && pwt_out == p, "R2 attributes held",
                    64'({cache_req, pwt_out}), 64'({c, p}));
            end else begin
                chk(cyc_done == 1'b1, (beats == 4) ? "R5 ends after four" : "R6 ends after one",
                    64'(cyc_done), 64'd1);
                chk(line_valid == (beats == 4), "R9 line valid pulse", 64'(line_valid),
                    64'(beats == 4));
                chk(line_state == exp_state, "R7 line state (R4 late inputs ignored)",
                    64'(line_state), 64'(exp_state));
                chk(req_ready == 1'b1 && cache_req == 1'b0, "R9 back to idle",
                    64'({req_ready, cache_req}), 64'b10);
            end
        end
        for (int b = 0; b < beats; b++) begin
            rd_idx = 2'(f) ^ 2'(b);
            #1;
            chk(rd_data == beat_data(run_no, b), "R8 interleaved slot", rd_data,
                beat_data(run_no, b));
        end
        @(negedge clk);
        chk(cyc_done == 1'b0 && line_valid == 1'b0 && line_state == 2'd0,
            "R9 pulse one clock", 64'({cyc_done, line_valid, line_state}), 64'd0);
        run_no++;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired after %0d checks", checks);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(req_ready == 1'b1 && addr_strobe == 1'b0 && cache_req == 1'b0 &&
            pwt_out == 1'b0 && cyc_done == 1'b0 && line_valid == 1'b0,
            "R10 reset outputs", 64'({req_ready, addr_strobe, cache_req, pwt_out,
            cyc_done, line_valid}), 64'b100000);
        rst = 1'b0;
        @(negedge clk);
        for (int c = 0; c < 2; c++)
            for (int p = 0; p < 2; p++)
                for (int k = 0; k < 2; k++)
                    for (int w = 0; w < 2; w++)
                        for (int f = 0; f < 4; f++)
                            for (int ws = 0; ws < 3; ws++)
                                one_cycle(c[0], p[0], k[0], w[0], f, ws);
        // R10 reset in the middle of a burst
        req_valid = 1'b1; req_addr = 32'h100; req_cacheable = 1'b1; req_pwt = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        rdy_in = 1'b1; ken_in = 1'b1; wbwt_in = 1'b1;
        @(negedge clk);
        rdy_in = 1'b0; rst = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && cache_req == 1'b0 && cyc_done == 1'b0,
            "R10 mid-cycle reset", 64'({req_ready, cache_req, cyc_done}), 64'b100);
        rst = 1'b0;
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule